// File: doc/BRIEF.md
# Trigger-Accept Event Filter

This block sits in a detector readout path between a source of time-ordered hit packets and the memory that keeps accepted events. Each packet carries the number of the beam crossing that produced it. The block runs its own crossing counter. It also derives a lagged crossing value, which is the current count minus a programmable trigger latency. When an accept decision arrives, the lagged value names the crossing that the decision belongs to. That crossing goes into a small queue of pending accepted crossings, together with a running event number.

Packets are compared only against the head of that queue, because both the data and the queue are ordered in time:
- A packet whose crossing lies within a programmable window around the head crossing is forwarded and tagged with the head's event number.
- A packet older than the window is discarded.
- A packet newer than the window retires the head. Retiring the head emits an end-of-event marker, and the same packet is then compared against the next entry.

When no accept is pending, packets too old to match any future accept are discarded, and all other packets are held. All crossing arithmetic is modulo the counter width.

The controller has three states:
- ST_EMPTY: no accept is pending.
- ST_MATCH: the incoming packet is compared with the head entry.
- ST_RETIRE: the end-of-event marker is emitted and the head is popped.

The transitions are:
- ST_EMPTY to ST_MATCH when the queue becomes non-empty.
- ST_MATCH to ST_RETIRE on a packet later than the window.
- ST_MATCH to ST_EMPTY when the queue is found empty.
- ST_RETIRE to ST_MATCH unconditionally.

Top module: `trig_event_filter`

## Requirements
- R1: The crossing counter is 12 bits wide. It is zero after reset and advances by one, modulo 4096, in each cycle where `bx_tick` is high.
- R2: An accept (`l1_accept` high for one cycle) records the crossing (count − `cfg_latency`) mod 4096. The count used is the value before any advance in the same cycle. Latencies from 0 to 40 are honoured.
- R3: Let d = (packet crossing − head crossing), read as a signed 12-bit value. A packet with −W ≤ d ≤ W, where W is `cfg_window`, is consumed (`in_ready` high). One cycle later it appears with `out_eoe`=0, `out_bx`=packet crossing, `out_data`=packet payload and `out_evt`=head event number.
- R4: A packet with d < −W is consumed and produces no output.
- R5: A packet with d > W is not consumed. The cycle after it is seen, the head is retired. The next output is `out_eoe`=1 with `out_bx`=head crossing and `out_evt`=head event number. The same packet is then compared against the following entry.
- R6: The event number starts at 0 after reset and increases by one on every accept, including accepts that are dropped. Each queued crossing carries the value the counter had when its accept arrived.
- R7: The queue holds 8 entries. An accept that arrives while the queue is full, and with no retirement in the same cycle, is dropped, and `ovf_pulse` is high for one cycle in the following cycle. An accept that coincides with a retirement on a full queue is stored.
- R8: With no pending accept, a packet whose crossing is more than W crossings older than the lagged crossing, (lag − crossing) > W, is consumed with no output. Any other packet is held (`in_ready` low).
- R9: All comparisons in R3, R4, R5 and R8 are modulo 4096 and stay correct across counter wraparound.
- R10: After reset, `out_valid`, `ovf_pulse` and `in_ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bx_tick | input | 1 | Advance the crossing counter this cycle |
| l1_accept | input | 1 | Trigger accept strobe |
| cfg_latency | input | 6 | Trigger latency in crossings (0..40) |
| cfg_window | input | 4 | Half-width of the match window in crossings |
| in_valid | input | 1 | Incoming packet present |
| in_bx | input | 12 | Crossing number of the incoming packet |
| in_data | input | 16 | Payload of the incoming packet |
| in_ready | output | 1 | Packet consumed this cycle |
| out_valid | output | 1 | Output word valid |
| out_eoe | output | 1 | 1 = end-of-event marker, 0 = forwarded hit |
| out_bx | output | 12 | Hit crossing, or the retired accepted crossing |
| out_data | output | 16 | Hit payload; zero on a marker |
| out_evt | output | 8 | Event number of the owning accept |
| ovf_pulse | output | 1 | An accept was dropped because the queue was full |

## Verification
A new accept and the retirement of the head can land in the same cycle. On a full queue, this decides whether the new crossing is stored or lost. The bench fills the queue to 8 entries, presents a packet that is later than the head's window, and raises the accept exactly in the cycle the controller sits in ST_RETIRE. It then judges the outcome at the ports: `ovf_pulse` must stay low, and the retirement sequence must end with a marker carrying the ninth event number. A separate test drives a ninth accept with no retirement and expects a single overflow pulse, with that event number absent from the markers.

// File: rtl/tef_pkg.sv
package tef_pkg;

    typedef enum logic [1:0] {
        ST_EMPTY  = 2'd0,
        ST_MATCH  = 2'd1,
        ST_RETIRE = 2'd2
    } tef_state_e;

    localparam int unsigned MAX_LATENCY = 40;

endpackage

// File: rtl/tef_bx_timer.sv
module tef_bx_timer #(
    parameter int unsigned CW = 12,
    parameter int unsigned LW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bx_tick,
    input  logic [LW-1:0] cfg_latency,
    output logic [CW-1:0] bx_now,
    output logic [CW-1:0] bx_lag
);
    import tef_pkg::*;

    localparam logic [LW-1:0] LAT_LIMIT = LW'(MAX_LATENCY);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bx_now <= '0;
        end else if (bx_tick) begin
            bx_now <= bx_now + 1'b1;
        end
    end

    // Lagged crossing: the crossing an accept seen now refers to.
    assign bx_lag = bx_now - CW'(cfg_latency);

    AST_BX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        bx_tick |=> (bx_now == CW'($past(bx_now) + 1'b1))); // R1
    AST_BX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bx_tick |=> $stable(bx_now)); // R1

    always @(posedge clk) begin
        if (rst_n) begin
            AST_LAT_RANGE: assert (cfg_latency <= LAT_LIMIT); // R2
        end
    end

endmodule

// File: rtl/tef_accept_queue.sv
module tef_accept_queue #(
    parameter int unsigned CW     = 12,
    parameter int unsigned EW     = 8,
    parameter int unsigned QDEPTH = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_req,
    input  logic [CW-1:0] push_bx,
    input  logic          pop,
    output logic [CW-1:0] head_bx,
    output logic [EW-1:0] head_evt,
    output logic          not_empty,
    output logic          ovf_pulse
);
    localparam int unsigned AW   = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;
    localparam int unsigned CNTW = AW + 1;
    localparam logic [AW-1:0]   LAST_PTR = AW'(QDEPTH - 1);
    localparam logic [CNTW-1:0] FULL_CNT = CNTW'(QDEPTH);

    logic [CW-1:0]   slot_bx  [QDEPTH];
    logic [EW-1:0]   slot_evt [QDEPTH];
    logic [AW-1:0]   wr_ptr, rd_ptr;
    logic [CNTW-1:0] count;
    logic [EW-1:0]   evt_next;
    logic            full, do_push, do_pop;

    assign full      = (count == FULL_CNT);
    assign do_pop    = pop && (count != '0);
    assign do_push   = push_req && (!full || do_pop);
    assign not_empty = (count != '0);
    assign head_bx   = slot_bx[rd_ptr];
    assign head_evt  = slot_evt[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) begin
            slot_bx[wr_ptr]  <= push_bx;
            slot_evt[wr_ptr] <= evt_next;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr    <= '0;
            rd_ptr    <= '0;
            count     <= '0;
            evt_next  <= '0;
            ovf_pulse <= 1'b0;
        end else begin
            ovf_pulse <= push_req && !do_push;
            if (push_req) begin
                evt_next <= evt_next + 1'b1;
            end
            if (do_push) begin
                wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
            end
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT); // R7
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && full && !pop) |=> (ovf_pulse && count == $past(count))); // R7
    AST_SWAP_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && full && pop) |=> (!ovf_pulse && count == FULL_CNT)); // R7
    AST_EVT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        push_req |=> (evt_next == EW'($past(evt_next) + 1'b1))); // R6
    AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> not_empty); // R5

endmodule

// File: rtl/tef_match_fsm.sv
module tef_match_fsm #(
    parameter int unsigned CW = 12,
    parameter int unsigned EW = 8,
    parameter int unsigned WW = 4,
    parameter int unsigned DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [CW-1:0] in_bx,
    input  logic [DW-1:0] in_data,
    input  logic [WW-1:0] cfg_window,
    input  logic [CW-1:0] bx_lag,
    input  logic          q_not_empty,
    input  logic [CW-1:0] head_bx,
    input  logic [EW-1:0] head_evt,
    output logic          in_ready,
    output logic          pop,
    output logic          out_valid,
    output logic          out_eoe,
    output logic [CW-1:0] out_bx,
    output logic [DW-1:0] out_data,
    output logic [EW-1:0] out_evt
);
    import tef_pkg::*;

    tef_state_e st, nxt;

    logic [CW-1:0]      d_head_u, d_lag_u, d_out_u;
    logic signed [CW:0] d_head, d_lag, d_out, w_pos, w_neg;
    logic               late, early, stale, fwd;

    // Signed modulo distances (survive counter wraparound)
    assign d_head_u = in_bx - head_bx;
    assign d_lag_u  = bx_lag - in_bx;
    assign d_head   = $signed({d_head_u[CW-1], d_head_u});
    assign d_lag    = $signed({d_lag_u[CW-1], d_lag_u});
    assign w_pos    = $signed({{(CW+1-WW){1'b0}}, cfg_window});
    assign w_neg    = -w_pos;
    assign late     = d_head > w_pos;
    assign early    = d_head < w_neg;
    assign stale    = d_lag > w_pos;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_EMPTY;
        end else begin
            st <= nxt;
        end
    end

    always_comb begin
        nxt      = st;
        in_ready = 1'b0;
        pop      = 1'b0;
        fwd      = 1'b0;
        unique case (st)
            ST_EMPTY: begin
                if (q_not_empty) begin
                    nxt = ST_MATCH;
                end else if (in_valid && stale) begin
                    in_ready = 1'b1;
                end
            end
            ST_MATCH: begin
                if (!q_not_empty) begin
                    nxt = ST_EMPTY;
                end else if (in_valid) begin
                    if (late) begin
                        nxt = ST_RETIRE;
                    end else begin
                        in_ready = 1'b1;
                        fwd      = !early;
                    end
                end
            end
            ST_RETIRE: begin
                pop = 1'b1;
                nxt = ST_MATCH;
            end
            default: nxt = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_eoe   <= 1'b0;
            out_bx    <= '0;
            out_data  <= '0;
            out_evt   <= '0;
        end else begin
            out_valid <= 1'b0;
            if (st == ST_RETIRE) begin
                out_valid <= 1'b1;
                out_eoe   <= 1'b1;
                out_bx    <= head_bx;
                out_data  <= '0;
                out_evt   <= head_evt;
            end else if (fwd) begin
                out_valid <= 1'b1;
                out_eoe   <= 1'b0;
                out_bx    <= in_bx;
                out_data  <= in_data;
                out_evt   <= head_evt;
            end
        end
    end

    assign d_out_u = out_bx - head_bx;
    assign d_out   = $signed({d_out_u[CW-1], d_out_u});

    AST_RETIRE_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RETIRE) |=> (out_valid && out_eoe && out_evt == $past(head_evt)
                               && out_bx == $past(head_bx))); // R5
    AST_HIT_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_eoe) |-> (d_out <= w_pos && d_out >= w_neg)); // R3
    AST_EMPTY_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_EMPTY) |=> !out_valid); // R8
    AST_RETIRE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RETIRE) |-> !in_ready); // R5

endmodule

// File: rtl/trig_event_filter.sv
module trig_event_filter #(
    parameter int unsigned CW     = 12,
    parameter int unsigned EW     = 8,
    parameter int unsigned QDEPTH = 8,
    parameter int unsigned LW     = 6,
    parameter int unsigned WW     = 4,
    parameter int unsigned DW     = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bx_tick,
    input  logic          l1_accept,
    input  logic [LW-1:0] cfg_latency,
    input  logic [WW-1:0] cfg_window,
    input  logic          in_valid,
    input  logic [CW-1:0] in_bx,
    input  logic [DW-1:0] in_data,
    output logic          in_ready,
    output logic          out_valid,
    output logic          out_eoe,
    output logic [CW-1:0] out_bx,
    output logic [DW-1:0] out_data,
    output logic [EW-1:0] out_evt,
    output logic          ovf_pulse
);
    logic [CW-1:0] bx_now, bx_lag, head_bx;
    logic [EW-1:0] head_evt;
    logic          q_not_empty, pop;

    tef_bx_timer #(.CW(CW), .LW(LW)) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .bx_tick     (bx_tick),
        .cfg_latency (cfg_latency),
        .bx_now      (bx_now),
        .bx_lag      (bx_lag)
    );

    tef_accept_queue #(.CW(CW), .EW(EW), .QDEPTH(QDEPTH)) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_req  (l1_accept),
        .push_bx   (bx_lag),
        .pop       (pop),
        .head_bx   (head_bx),
        .head_evt  (head_evt),
        .not_empty (q_not_empty),
        .ovf_pulse (ovf_pulse)
    );

    tef_match_fsm #(.CW(CW), .EW(EW), .WW(WW), .DW(DW)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_bx       (in_bx),
        .in_data     (in_data),
        .cfg_window  (cfg_window),
        .bx_lag      (bx_lag),
        .q_not_empty (q_not_empty),
        .head_bx     (head_bx),
        .head_evt    (head_evt),
        .in_ready    (in_ready),
        .pop         (pop),
        .out_valid   (out_valid),
        .out_eoe     (out_eoe),
        .out_bx      (out_bx),
        .out_data    (out_data),
        .out_evt     (out_evt)
    );

    AST_MARK_AFTER_POP: assert property (@(posedge clk) disable iff (!rst_n)
        pop |=> (out_valid && out_eoe)); // R5
    AST_OVF_ONLY_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |-> $past(l1_accept)); // R7

endmodule

// File: tb/trig_event_filter_tb.sv
module trig_event_filter_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bx_tick = 1'b0;
    logic        l1_accept = 1'b0;
    logic [5:0]  cfg_latency = 6'd12;
    logic [3:0]  cfg_window = 4'd0;
    logic        in_valid = 1'b0;
    logic [11:0] in_bx = '0;
    logic [15:0] in_data = '0;
    logic        in_ready, out_valid, out_eoe, ovf_pulse;
    logic [11:0] out_bx;
    logic [15:0] out_data;
    logic [7:0]  out_evt;

    always #2.5 clk = ~clk;

    trig_event_filter u_dut (
        .clk(clk), .rst_n(rst_n), .bx_tick(bx_tick), .l1_accept(l1_accept),
        .cfg_latency(cfg_latency), .cfg_window(cfg_window),
        .in_valid(in_valid), .in_bx(in_bx), .in_data(in_data), .in_ready(in_ready),
        .out_valid(out_valid), .out_eoe(out_eoe), .out_bx(out_bx),
        .out_data(out_data), .out_evt(out_evt), .ovf_pulse(ovf_pulse)
    );

    int n_chk = 0;
    int n_fail = 0;
    int bx_model = 0;
    int lg_n = 0;
    int ovf_n = 0;
    logic        lg_eoe  [64];
    logic [11:0] lg_bx   [64];
    logic [15:0] lg_data [64];
    logic [7:0]  lg_evt  [64];

    always @(negedge clk) begin
        if (rst_n && out_valid && lg_n < 64) begin
            lg_eoe[lg_n]  = out_eoe;
            lg_bx[lg_n]   = out_bx;
            lg_data[lg_n] = out_data;
            lg_evt[lg_n]  = out_evt;
            lg_n++;
        end
        if (rst_n && ovf_pulse) ovf_n++;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_entry(input int idx, input bit eoe, input int bx, input int evt,
                             input int data, input string tag);
        chk(lg_n > idx, {tag, " entry present"}, lg_n, idx + 1);
        if (lg_n > idx) begin
            chk(lg_eoe[idx] == eoe, {tag, " kind"}, int'(lg_eoe[idx]), int'(eoe));
            chk(int'(lg_bx[idx]) == bx, {tag, " crossing"}, int'(lg_bx[idx]), bx);
            chk(int'(lg_evt[idx]) == evt, {tag, " event"}, int'(lg_evt[idx]), evt);
            if (!eoe) chk(int'(lg_data[idx]) == data, {tag, " data"}, int'(lg_data[idx]), data);
        end
    endtask

    task automatic do_reset(input int lat, input int win);
        @(negedge clk);
        rst_n = 1'b0; bx_tick = 1'b0; l1_accept = 1'b0; in_valid = 1'b0;
        cfg_latency = 6'(lat); cfg_window = 4'(win);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        bx_model = 0; lg_n = 0; ovf_n = 0;
    endtask

    task automatic tick(input int n);
        @(negedge clk);
        bx_tick = 1'b1;
        repeat (n) @(negedge clk);
        bx_tick = 1'b0;
        bx_model = (bx_model + n) % 4096;
    endtask

    task automatic accept();
        @(negedge clk);
        l1_accept = 1'b1;
        @(negedge clk);
        l1_accept = 1'b0;
    endtask

    task automatic send(input int bx, input int data, output bit took);
        @(negedge clk);
        in_valid = 1'b1; in_bx = 12'(bx); in_data = 16'(data);
        took = 1'b0;
        for (int i = 0; i < 40; i++) begin
            #1;
            took = in_ready;
            @(negedge clk);
            if (took) break;
        end
        in_valid = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        bit r;
        do_reset(12, 0);
        #1;
        r = in_ready;
        chk(out_valid == 1'b0, "R10 out_valid after reset", int'(out_valid), 0);
        chk(ovf_pulse == 1'b0, "R10 ovf_pulse after reset", int'(ovf_pulse), 0);
        chk(r == 1'b0, "R10 in_ready after reset", int'(r), 0);
    endtask

    task automatic t_exact_match();
        bit took;
        do_reset(12, 0);
        tick(20);                       // R1: counter at 20
        accept();                       // R2: crossing 8
        send(8, 16'hA1, took);
        chk(took, "R3 matching packet consumed", int'(took), 1);
        send(9, 16'hA2, took);
        chk(!took, "R8 newer packet held after retire", int'(took), 0);
        settle();
        chk(lg_n == 2, "R5 output count", lg_n, 2);
        chk_entry(0, 0, 8, 0, 16'hA1, "R3 hit");
        chk_entry(1, 1, 8, 0, 0, "R5 marker");
    endtask

    task automatic t_stale();
        bit took;
        do_reset(12, 0);
        tick(30);                       // lag = 18
        send(3, 16'hB0, took);
        chk(took, "R8 stale packet dropped while idle", int'(took), 1);
        send(18, 16'hB1, took);
        chk(!took, "R8 live packet held while idle", int'(took), 0);
        accept();                       // crossing 18
        send(15, 16'hB2, took);
        chk(took, "R4 old packet consumed", int'(took), 1);
        send(18, 16'hB3, took);
        settle();
        chk(lg_n == 1, "R4 only the match emitted", lg_n, 1);
        chk_entry(0, 0, 18, 0, 16'hB3, "R4 hit");
    endtask

    task automatic t_window();
        bit took;
        do_reset(12, 2);
        tick(50);
        accept();                       // crossing 38
        send(35, 16'hC0, took);
        send(36, 16'hC1, took);
        send(40, 16'hC2, took);
        chk(took, "R3 upper window edge consumed", int'(took), 1);
        send(41, 16'hC3, took);
        chk(!took, "R5 beyond window held", int'(took), 0);
        settle();
        chk(lg_n == 3, "R3 window output count", lg_n, 3);
        chk_entry(0, 0, 36, 0, 16'hC1, "R3 lower edge hit");
        chk_entry(1, 0, 40, 0, 16'hC2, "R3 upper edge hit");
        chk_entry(2, 1, 38, 0, 0, "R5 window marker");
    endtask

    task automatic t_two_events();
        bit took;
        do_reset(12, 1);
        tick(20);
        accept();                       // crossing 8, event 0
        tick(5);
        accept();                       // crossing 13, event 1
        send(8, 16'hD0, took);
        send(12, 16'hD1, took);
        chk(took, "R5 packet reused after retire", int'(took), 1);
        send(20, 16'hD2, took);
        settle();
        chk(lg_n == 4, "R6 two-event output count", lg_n, 4);
        chk_entry(0, 0, 8, 0, 16'hD0, "R6 first hit");
        chk_entry(1, 1, 8, 0, 0, "R6 first marker");
        chk_entry(2, 0, 12, 1, 16'hD1, "R6 second hit");
        chk_entry(3, 1, 13, 1, 0, "R6 second marker");
    endtask

    task automatic t_wrap();
        bit took;
        do_reset(12, 0);
        tick(4101);                     // counter 5, lag 4089
        send(4085, 16'hE0, took);
        chk(took, "R9 stale across wrap dropped", int'(took), 1);
        accept();                       // crossing 4089
        send(4089, 16'hE1, took);
        send(3, 16'hE2, took);
        chk(!took, "R9 later packet after wrap held", int'(took), 0);
        settle();
        chk(lg_n == 2, "R9 wrap output count", lg_n, 2);
        chk_entry(0, 0, 4089, 0, 16'hE1, "R9 hit");
        chk_entry(1, 1, 4089, 0, 0, "R9 marker");
    endtask

    task automatic t_long_latency();
        bit took;
        do_reset(40, 0);
        tick(100);
        accept();                       // crossing 60
        send(60, 16'hF0, took);
        settle();
        chk_entry(0, 0, 60, 0, 16'hF0, "R2 latency 40");
    endtask

    task automatic t_overflow();
        bit took;
        do_reset(12, 0);
        tick(20);
        for (int i = 0; i < 9; i++) accept();
        settle();
        chk(ovf_n == 1, "R7 one overflow pulse", ovf_n, 1);
        send(8, 16'h77, took);
        send(9, 16'h78, took);
        settle();
        chk(lg_n == 9, "R7 stored events", lg_n, 9);
        chk_entry(1, 1, 8, 0, 0, "R7 first marker");
        chk_entry(8, 1, 8, 7, 0, "R7 last marker");
    endtask

    task automatic t_swap_when_full();
        do_reset(12, 0);
        tick(20);
        for (int i = 0; i < 8; i++) accept();
        settle();
        @(negedge clk);
        in_valid = 1'b1; in_bx = 12'd9; in_data = 16'h0;
        @(negedge clk);                 // controller now retiring
        l1_accept = 1'b1;
        @(negedge clk);
        l1_accept = 1'b0;
        repeat (30) @(negedge clk);
        in_valid = 1'b0;
        settle();
        chk(ovf_n == 0, "R7 accept during retire kept", ovf_n, 0);
        chk(lg_n == 9, "R7 marker count with swap", lg_n, 9);
        chk_entry(8, 1, 8, 8, 0, "R7 swapped-in event");
    endtask

    task automatic finish_up();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        finish_up();
    end

    initial begin
        t_reset();
        t_exact_match();
        t_stale();
        t_window();
        t_two_events();
        t_wrap();
        t_long_latency();
        t_overflow();
        t_swap_when_full();
        finish_up();
    end

endmodule